// File: doc/BRIEF.md
# SPI Channel Transfer Sequencer

This block is a single channel of a multichannel SPI master. It keeps the channel's configuration, status, enable, transmit word and receive word. It decides whether a transfer attempt may run, shifts a word of programmable length out on MOSI while it captures MISO, and updates the status flags once the word completes. It also drives DMA request levels for transmit and receive, and one-cycle transmit-empty and receive-full event pulses that an interrupt aggregator collects.

Three actions start a transfer attempt: writing the transmit word, reading the receive word, and switching the channel enable from 0 to 1. The attempt is held in a pending latch and is judged one cycle later against the current flags, the transfer mode and the turbo bit. Register reads return data on the cycle after the read strobe. SCLK idles low. MOSI changes on the falling edge and MISO is sampled on the rising edge. Each half period of SCLK lasts `HALF_DIV` system clocks.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset the configuration reads 0x060000, the status reads 0x2 (only transmit-empty set), the enable reads 0, chip select is high and both DMA requests are low.
- R2: Register addresses are 0 configuration, 1 status (read-only), 2 enable (bit 0), 3 transmit word, 4 receive word (read-only). A configuration write keeps bits 22:0. Its fields are word length at 11:7, mode at 13:12 (0 duplex, 1 receive-only, 2 transmit-only), transmit DMA enable at 14, receive DMA enable at 15, turbo at 19 and force at 20. Status bits are receive-full 0, transmit-empty 1 and end-of-transfer 2.
- R3: An attempt made while the channel is disabled shifts nothing and changes no status flag.
- R4: An attempt is blocked when receive-full is set with mode not transmit-only and turbo off, or when transmit-empty is set with mode not receive-only.
- R5: A transmit write stores the word, clears transmit-empty and makes an attempt. A receive read returns the word, clears receive-full and makes an attempt. An enable change from 0 to 1 makes an attempt.
- R6: A transfer drives chip select low and sends word-length+1 bits, most significant bit first. The SCLK period is 2*HALF_DIV clocks and SCLK is low whenever chip select is high.
- R7: On the cycle after the last bit, the transmit word clears to 0 and end-of-transfer and transmit-empty are set. Receive-full is set unless the mode is transmit-only, and the receive word takes the captured bits.
- R8: With the single-channel input high and force clear, a transfer leaves SCLK, MOSI and chip select idle, updates the status as in R7 and leaves the receive word unchanged. With force set, the pins are driven.
- R9: The transmit DMA request is high exactly when the channel is enabled, transmit DMA is enabled, transmit-empty is set and the mode is not receive-only.
- R10: The receive DMA request is high exactly when the channel is enabled, receive DMA is enabled, receive-full is set and the mode is not transmit-only.
- R11: A word-length field below 3 is treated as 3, which gives 4-bit transfers.
- R12: Register writes made during a shift neither restart nor abort it. Its length and data stay as they were latched at the start.
- R13: When an attempt resolves, either blocked or completed, the transmit-empty event pulses if transmit-empty is set and the mode is not receive-only. The receive-full event pulses if receive-full is set, the mode is not transmit-only and turbo is off.
- R14: End-of-transfer clears when a transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| single_mode_i | input | 1 | Module-level single-channel mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low chip select |
| tx_dreq_o | output | 1 | Transmit DMA request level |
| rx_dreq_o | output | 1 | Receive DMA request level |
| tx_empty_evt_o | output | 1 | Transmit-empty event pulse |
| rx_full_evt_o | output | 1 | Receive-full event pulse |

## Verification
The assertions assume the register port issues at most one strobe per cycle and never writes the transmit word while a shift is in progress. They also assume a configuration written mid-shift does not change the mode before completion is recorded. The stimulus issues every access through one-cycle write and read tasks. It waits for end-of-transfer before touching the transmit word again. The only mid-shift write it makes changes the word length alone, which checks R12 without changing the mode.

// File: rtl/spi_chan_pkg.sv
`timescale 1ns/1ps
package spi_chan_pkg;
  localparam int REG_W = 32;
  localparam int CFG_W = 23;

  localparam logic [2:0] A_CONF = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_TX   = 3'd3;
  localparam logic [2:0] A_RX   = 3'd4;

  localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

  localparam int B_WL_LO  = 7;
  localparam int B_MODE   = 12;
  localparam int B_TXDMA  = 14;
  localparam int B_RXDMA  = 15;
  localparam int B_TURBO  = 19;
  localparam int B_FORCE  = 20;

  typedef enum logic [1:0] {
    M_DUPLEX = 2'd0,
    M_RXONLY = 2'd1,
    M_TXONLY = 2'd2,
    M_RSVD   = 2'd3
  } xfer_mode_e;

  // field values below 3 are not allowed; they run as a 4-bit word
  function automatic int word_len(input logic [4:0] f);
    return (f < 5'd3) ? 4 : int'(f) + 1;
  endfunction
endpackage

// File: rtl/spi_chan_regs.sv
`timescale 1ns/1ps
module spi_chan_regs
  import spi_chan_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [2:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             rx_valid_i,
  input  logic [DW-1:0]    rx_word_i,
  output logic [4:0]       wl_o,
  output logic [1:0]       mode_o,
  output logic             turbo_o,
  output logic             force_o,
  output logic             en_o,
  output logic             txs_o,
  output logic             rxs_o,
  output logic [DW-1:0]    tx_word_o,
  output logic             att_o,
  output logic             tx_dreq_o,
  output logic             rx_dreq_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             en_q, txs_q, rxs_q, eot_q;
  logic [DW-1:0]    tx_q, rx_q;
  logic [REG_W-1:0] rdata_q;
  logic             txd_q, rxd_q;
  logic [1:0]       mode;

  assign mode = cfg_q[B_MODE+1:B_MODE];

  // attempt sources: TX write, RX read, enable rising
  assign att_o = (wr_i && addr_i == A_TX) ||
                 (rd_i && addr_i == A_RX) ||
                 (wr_i && addr_i == A_CTRL && wdata_i[0] && !en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_RST;
      en_q    <= 1'b0;
      txs_q   <= 1'b1;
      rxs_q   <= 1'b0;
      eot_q   <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      txd_q   <= 1'b0;
      rxd_q   <= 1'b0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          A_CONF: cfg_q <= wdata_i[CFG_W-1:0];
          A_CTRL: en_q  <= wdata_i[0];
          A_TX: begin
            tx_q  <= wdata_i[DW-1:0];
            txs_q <= 1'b0;
          end
          default: ;
        endcase
      end
      if (rd_i) begin
        case (addr_i)
          A_CONF:  rdata_q <= REG_W'(cfg_q);
          A_STAT:  rdata_q <= REG_W'({eot_q, txs_q, rxs_q});
          A_CTRL:  rdata_q <= REG_W'(en_q);
          A_TX:    rdata_q <= REG_W'(tx_q);
          A_RX: begin
            rdata_q <= REG_W'(rx_q);
            rxs_q   <= 1'b0;
          end
          default: rdata_q <= '0;
        endcase
      end
      if (start_i) eot_q <= 1'b0;
      if (done_i) begin
        tx_q  <= '0;
        eot_q <= 1'b1;
        txs_q <= 1'b1;
        if (mode != M_TXONLY) rxs_q <= 1'b1;
        if (rx_valid_i) rx_q <= rx_word_i;
      end
      txd_q <= en_q && cfg_q[B_TXDMA] && txs_q && (mode != M_RXONLY);
      rxd_q <= en_q && cfg_q[B_RXDMA] && rxs_q && (mode != M_TXONLY);
    end
  end

  assign rdata_o   = rdata_q;
  assign wl_o      = cfg_q[B_WL_LO+4:B_WL_LO];
  assign mode_o    = mode;
  assign turbo_o   = cfg_q[B_TURBO];
  assign force_o   = cfg_q[B_FORCE];
  assign en_o      = en_q;
  assign txs_o     = txs_q;
  assign rxs_o     = rxs_q;
  assign tx_word_o = tx_q;
  assign tx_dreq_o = txd_q;
  assign rx_dreq_o = rxd_q;

  p_tx_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (tx_q == '0) && txs_q && eot_q);
  p_rxs_set_r7: assert property (@(posedge clk) disable iff (rst)
    (done_i && mode != M_TXONLY) |=> rxs_q);
  p_eot_clear_r14: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !eot_q);
  p_gate_tx_r4: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !(txs_q && mode != M_RXONLY));
  p_gate_rx_r4: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !(rxs_q && mode != M_TXONLY && !cfg_q[B_TURBO]));
endmodule

// File: rtl/spi_chan_gate.sv
`timescale 1ns/1ps
module spi_chan_gate
  import spi_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       att_i,
  input  logic       busy_i,
  input  logic       done_i,
  input  logic       en_i,
  input  logic       txs_i,
  input  logic       rxs_i,
  input  logic [1:0] mode_i,
  input  logic       turbo_i,
  output logic       start_o,
  output logic       tx_evt_o,
  output logic       rx_evt_o
);
  logic pend_q, eval_q, txe_q, rxe_q;
  logic consume, rx_block, tx_block, blk;

  // an attempt waits while a shift runs or its completion is being recorded
  assign consume  = pend_q && !busy_i && !done_i;
  assign rx_block = rxs_i && (mode_i != M_TXONLY) && !turbo_i;
  assign tx_block = txs_i && (mode_i != M_RXONLY);
  assign blk      = consume && en_i && (rx_block || tx_block);
  assign start_o  = consume && en_i && !(rx_block || tx_block);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      eval_q <= 1'b0;
      txe_q  <= 1'b0;
      rxe_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q && !consume) || att_i;
      eval_q <= blk || done_i;
      txe_q  <= eval_q && txs_i && (mode_i != M_RXONLY);
      rxe_q  <= eval_q && rxs_i && (mode_i != M_TXONLY) && !turbo_i;
    end
  end

  assign tx_evt_o = txe_q;
  assign rx_evt_o = rxe_q;

  p_start_en_r3: assert property (@(posedge clk) disable iff (rst)
    start_o |-> en_i);
  p_start_idle_r12: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !busy_i);
  p_evt_excl_r13: assert property (@(posedge clk) disable iff (rst)
    rx_evt_o |-> $past(mode_i) != M_TXONLY);
endmodule

// File: rtl/spi_chan_shifter.sv
`timescale 1ns/1ps
module spi_chan_shifter
  import spi_chan_pkg::*;
#(
  parameter int DW       = 32,
  parameter int HALF_DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          drive_i,
  input  logic [4:0]    wl_i,
  input  logic [DW-1:0] word_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_word_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          cs_n_o
);
  localparam int SHW  = $clog2(DW + 1);
  localparam int DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic            busy_q, done_q, rxv_q, sclk_q, cs_n_q;
  logic [DW-1:0]   shreg_q, rxsh_q, rxw_q;
  logic [SHW-1:0]  bitcnt_q, len_q, len_w;
  logic [DIVW-1:0] div_q;

  assign len_w = (word_len(wl_i) > DW) ? SHW'(DW) : SHW'(word_len(wl_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rxv_q    <= 1'b0;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      shreg_q  <= '0;
      rxsh_q   <= '0;
      rxw_q    <= '0;
      bitcnt_q <= '0;
      len_q    <= '0;
      div_q    <= '0;
    end else begin
      done_q <= 1'b0;
      rxv_q  <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (drive_i) begin
            busy_q   <= 1'b1;
            cs_n_q   <= 1'b0;
            shreg_q  <= word_i << (SHW'(DW) - len_w);
            rxsh_q   <= '0;
            bitcnt_q <= '0;
            div_q    <= '0;
            len_q    <= len_w;
          end else begin
            done_q <= 1'b1;
          end
        end
      end else if (div_q == DIVW'(HALF_DIV - 1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rxsh_q <= {rxsh_q[DW-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bitcnt_q == len_q - 1'b1) begin
            busy_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            rxv_q   <= 1'b1;
            rxw_q   <= rxsh_q;
            shreg_q <= '0;
          end else begin
            shreg_q  <= shreg_q << 1;
            bitcnt_q <= bitcnt_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign rx_valid_o = rxv_q;
  assign rx_word_o  = rxw_q;
  assign sclk_o     = sclk_q;
  assign mosi_o     = shreg_q[DW-1];
  assign cs_n_o     = cs_n_q;

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sclk_q);
  p_bitcnt_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> bitcnt_q < len_q);
  p_len_min_r11: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> len_q >= SHW'(4));
endmodule

// File: rtl/spi_chan_seq.sv
`timescale 1ns/1ps
module spi_chan_seq
  import spi_chan_pkg::*;
#(
  parameter int DW       = 32,
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        single_mode_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_n_o,
  output logic        tx_dreq_o,
  output logic        rx_dreq_o,
  output logic        tx_empty_evt_o,
  output logic        rx_full_evt_o
);
  logic          start, done, busy, rx_valid, att;
  logic          en, txs, rxs, turbo, force_bit;
  logic [4:0]    wl;
  logic [1:0]    mode;
  logic [DW-1:0] tx_word, rx_word;

  spi_chan_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .start_i(start), .done_i(done), .rx_valid_i(rx_valid), .rx_word_i(rx_word),
    .wl_o(wl), .mode_o(mode), .turbo_o(turbo), .force_o(force_bit),
    .en_o(en), .txs_o(txs), .rxs_o(rxs), .tx_word_o(tx_word), .att_o(att),
    .tx_dreq_o(tx_dreq_o), .rx_dreq_o(rx_dreq_o)
  );

  spi_chan_gate u_gate (
    .clk(clk), .rst(rst),
    .att_i(att), .busy_i(busy), .done_i(done),
    .en_i(en), .txs_i(txs), .rxs_i(rxs), .mode_i(mode), .turbo_i(turbo),
    .start_o(start), .tx_evt_o(tx_empty_evt_o), .rx_evt_o(rx_full_evt_o)
  );

  spi_chan_shifter #(.DW(DW), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst),
    .start_i(start), .drive_i(!single_mode_i || force_bit),
    .wl_i(wl), .word_i(tx_word), .miso_i(miso_i),
    .busy_o(busy), .done_o(done), .rx_valid_o(rx_valid), .rx_word_o(rx_word),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o)
  );
endmodule

// File: tb/spi_chan_seq_tb.sv
`timescale 1ns/1ps
module spi_chan_seq_tb;
  localparam logic [2:0] CONF = 3'd0, STAT = 3'd1, CTRL = 3'd2, TXR = 3'd3, RXR = 3'd4;

  // {word-length field, mode, tx word, slave pattern}
  localparam logic [70:0] VEC [4] = '{
    {5'd7,  2'd0, 32'h000000A5, 32'h0000003C},
    {5'd15, 2'd0, 32'h00001234, 32'h0000BEEF},
    {5'd31, 2'd0, 32'hDEADBEEF, 32'h12345678},
    {5'd4,  2'd2, 32'h00000015, 32'h0000000A}
  };

  logic clk = 1'b0, rst = 1'b1, single = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, miso, cs_n, txd, rxd, txe, rxe;

  int nchk = 0, nerr = 0;
  int xfers = 0, nbits = 0, ntxe = 0, nrxe = 0;
  logic [31:0] mo = '0, sl = '0, pat_cur = '0;
  int len_cur = 8;
  realtime t_last = 0, t_prev = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  spi_chan_seq u_dut (
    .clk(clk), .rst(rst), .single_mode_i(single),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .cs_n_o(cs_n), .tx_dreq_o(txd), .rx_dreq_o(rxd),
    .tx_empty_evt_o(txe), .rx_full_evt_o(rxe)
  );

  // serial slave model
  always @(negedge cs_n) begin
    xfers++;
    sl = pat_cur << (32 - len_cur);
    mo = '0;
    nbits = 0;
  end
  always @(posedge sclk) begin
    mo = {mo[30:0], mosi};
    nbits++;
    t_prev = t_last;
    t_last = $realtime;
  end
  always @(negedge sclk) sl = sl << 1;
  assign miso = sl[31];

  always @(posedge clk) if (!rst) begin
    if (txe) ntxe++;
    if (rxe) nrxe++;
  end

  function automatic logic [31:0] msk(input int n);
    return (n >= 32) ? 32'hFFFFFFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      rreg(STAT, s);
      if (s[2]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #4ms;
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int x0, e0, r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rreg(CONF, v); chk("R1 conf", v, 32'h060000);
    rreg(STAT, v); chk("R1 stat", v, 32'h2);
    rreg(CTRL, v); chk("R1 enable", v, 32'h0);
    chk("R1 pins/dreq", {29'd0, cs_n, txd, rxd}, 32'h4);
    // R2 mask
    wreg(CONF, 32'hFFFFFFFF); rreg(CONF, v); chk("R2 conf mask", v, 32'h7FFFFF);
    wreg(CONF, 32'h0);
    wreg(CTRL, 32'h1);

    // vector loop: R5 R6 R7
    foreach (VEC[i]) begin
      logic [4:0] f; logic [1:0] m; logic [31:0] tw, pw;
      {f, m, tw, pw} = VEC[i];
      pat_cur = pw; len_cur = int'(f) + 1;
      wreg(CONF, {18'd0, m, f, 7'd0});
      x0 = xfers;
      wreg(TXR, tw);
      wait_done();
      chk("R5 tx write starts", xfers - x0, 1);
      chk("R6 bit count", nbits, len_cur);
      chk("R6 mosi msb first", mo & msk(len_cur), tw & msk(len_cur));
      rreg(STAT, v); chk("R7 status", v, (m == 2'd2) ? 32'h6 : 32'h7);
      rreg(TXR, v); chk("R7 tx cleared", v, 32'h0);
      rreg(RXR, v); chk("R7 rx word", v, pw & msk(len_cur));
      repeat (3) @(negedge clk);
      rreg(STAT, v); chk("R5 rx read clears", v, 32'h6);
    end
    chk("R6 sclk period", (t_last - t_prev == 80.0) ? 32'd1 : 32'd0, 32'd1);

    // R4/R13: blocked by unread receive word
    pat_cur = 32'h5A; len_cur = 8;
    wreg(CONF, 32'h380);
    wreg(TXR, 32'h11); wait_done();
    x0 = xfers; e0 = ntxe; r0 = nrxe;
    wreg(TXR, 32'h3C);
    repeat (8) @(negedge clk);
    chk("R4 rx-full blocks", xfers - x0, 0);
    chk("R13 tx evt on block", ntxe - e0, 0);
    chk("R13 rx evt on block", nrxe - r0, 1);
    rreg(RXR, v); chk("R5 rx read data", v, 32'h5A);
    wait_done();
    chk("R5 rx read starts", xfers - x0, 1);
    chk("R5 queued word sent", mo & 32'hFF, 32'h3C);
    chk("R13 events at completion", (ntxe - e0) * 16 + (nrxe - r0), 32'h12);

    // turbo lets a second word go without reading
    wreg(CONF, 32'h80380);
    x0 = xfers; pat_cur = 32'h77;
    wreg(TXR, 32'h42); wait_done();
    chk("R4 turbo ignores rx-full", xfers - x0, 1);
    rreg(RXR, v); chk("R7 turbo rx word", v, 32'h77);

    // R3 disabled channel
    wreg(CONF, 32'h380);
    repeat (4) @(negedge clk);
    wreg(CTRL, 32'h0);
    x0 = xfers;
    wreg(TXR, 32'h99);
    repeat (8) @(negedge clk);
    chk("R3 no shift when disabled", xfers - x0, 0);
    rreg(STAT, v); chk("R3 status untouched", v, 32'h4);
    wreg(CTRL, 32'h1); wait_done();
    chk("R5 enable rise starts", xfers - x0, 1);
    chk("R5 enable rise word", mo & 32'hFF, 32'h99);

    // receive-only mode; R9 R10
    pat_cur = 32'hC3;
    wreg(CONF, 32'h1380);
    x0 = xfers;
    rreg(RXR, v); wait_done();
    chk("R4 rx-only ignores tx-empty", xfers - x0, 1);
    chk("R4 rx-only sends zeros", mo & 32'hFF, 32'h0);
    wreg(CONF, 32'h1380 | 32'h8000 | 32'h4000);
    repeat (4) @(negedge clk);
    chk("R10 rx dreq", rxd, 1'b1);
    chk("R9 tx dreq off rx-only", txd, 1'b0);
    wreg(CONF, 32'h0380 | 32'h4000);
    repeat (4) @(negedge clk);
    chk("R9 tx dreq", txd, 1'b1);
    wreg(CONF, 32'h2380 | 32'h8000);
    repeat (4) @(negedge clk);
    chk("R10 rx dreq off tx-only", rxd, 1'b0);

    // R8 single mode
    wreg(CONF, 32'h380);
    rreg(RXR, v); chk("R7 rx-only word", v, 32'hC3);
    single = 1'b1;
    x0 = xfers; e0 = nbits;
    wreg(TXR, 32'hE1); wait_done();
    chk("R8 pins idle", xfers - x0, 0);
    rreg(STAT, v); chk("R8 status updated", v, 32'h7);
    rreg(RXR, v); chk("R8 rx kept", v, 32'hC3);
    wreg(CONF, 32'h100380);
    pat_cur = 32'h2D;
    wreg(TXR, 32'hF0); wait_done();
    chk("R8 force drives", xfers - x0, 1);
    chk("R8 force word", mo & 32'hFF, 32'hF0);
    rreg(RXR, v);
    single = 1'b0;

    // R11 short word length
    wreg(CONF, 32'h080);
    pat_cur = 32'h6; len_cur = 4;
    wreg(TXR, 32'hFB); wait_done();
    chk("R11 four bits", nbits, 4);
    chk("R11 low nibble", mo & 32'hF, 32'hB);
    rreg(RXR, v); chk("R11 rx nibble", v, 32'h6);

    // R12 config write mid-shift
    wreg(CONF, 32'hF80);
    pat_cur = 32'hA0A0A0A0; len_cur = 32;
    wreg(TXR, 32'h13579BDF);
    repeat (12) @(negedge clk);
    wreg(CONF, 32'h380);
    wait_done();
    chk("R12 length kept", nbits, 32);
    chk("R12 data kept", mo, 32'h13579BDF);
    rreg(STAT, v); chk("R14 eot set after", v, 32'h7);

    finish_run();
  end
endmodule